// File: doc/BRIEF.md
# Modem Control Loopback Unit

This unit sits between a serial port's control registers and its receive queue. It steers modem-status flags, modem interrupt bits and receive data, and it has two modes. With loopback off, the four modem-status flags track the external modem input pins. Characters and break events from the external receiver feed the receive queue. With loopback on, the port's own modem-control outputs are reflected onto those flags. Every transmit-data write becomes a received character. A newly asserted send-break becomes a received break word. External receive characters are dropped.

The modem flags and control outputs share one 4-bit index order: bit 0 ring indicator / Out2, bit 1 carrier detect / Out1, bit 2 clear-to-send / RTS, bit 3 data-set-ready / DTR. In loopback, flag i therefore follows control bit i. A receive word is `DATA_W+3` bits wide, which is 11 by default. The character sits in the low `DATA_W` bits and bit 10 (the top bit) marks a break. The two bits between them are zero.

Register writes take effect on the next clock edge. The receive push is combinational, so a push appears in the same cycle as the event that causes it and only while the queue reports ready. An event that cannot be pushed is lost.

Top module: `modem_loop_unit`

## Requirements
- R1: After reset the modem flags, the modem interrupt bits and the break-error bit are 0, loopback and FIFO mode are off, and no push is driven.
- R2: When loopback is on, the modem flags equal the stored modem-control bits index for index: RI=Out2 (bit 0), DCD=Out1 (bit 1), CTS=RTS (bit 2), DSR=DTR (bit 3). The external pins are ignored.
- R3: A control write that sets the loopback bit applies the mapping from its own control values on the clock edge that stores it.
- R4: A control write with loopback set rebuilds the modem interrupt bits on that edge. All four are cleared, and each is then set where the written control bit is 1.
- R5: With loopback off, each flag takes its pin value one cycle later. A pin that is 1 while its flag is 0 sets its interrupt bit. Interrupt bits stay set until a 1 is written to the same position of the clear mask.
- R6: With loopback on, a transmit write pushes a word whose low 8 bits are the transmitted byte and whose bits 10:8 are 0.
- R7: With loopback on, a line-control write that takes send-break from 0 to 1 pushes the word 0x400 (bit 10 alone). A write that leaves send-break at 1, or clears it, pushes nothing.
- R8: External receive characters are pushed unchanged with loopback off, and are discarded with loopback on.
- R9: An external break event with FIFO mode off pushes 0x400 and sets the break-error bit on the next edge. With FIFO mode on it does neither. The error-clear input clears the bit.
- R10: No push is driven while the receive queue is not ready.
- R11: When several sources fire in one cycle, only one word is pushed, chosen in this order: transmit loopback, loopback break, external break, external character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_lbe | input | 1 | Loopback enable value being written |
| ctrl_mdm | input | 4 | Modem-control outputs being written {DTR,RTS,Out1,Out2} |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break value being written |
| lcr_fifo | input | 1 | FIFO-mode value being written |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmitted character |
| ext_rx_valid | input | 1 | External receiver has a character |
| ext_rx_data | input | DATA_W | External received character |
| ext_break | input | 1 | External break event |
| modem_pin | input | 4 | External modem inputs {DSR,CTS,DCD,RI} |
| ms_clr | input | 4 | Write-1-to-clear mask for modem interrupt bits |
| err_clr | input | 1 | Clears the break-error bit |
| rxq_ready | input | 1 | Receive queue can accept a word |
| rxq_push | output | 1 | Push strobe to the receive queue |
| rxq_word | output | DATA_W+3 | Word pushed; top bit marks a break |
| mdm_flags | output | 4 | Modem-status flags {DSR,CTS,DCD,RI} |
| ms_irq | output | 4 | Modem interrupt bits, same order |
| brk_err | output | 1 | Break-error status bit |

## Verification
On every cycle the assertions check the following. The flags track the pins one cycle later outside loopback. A loopback-enabling control write leaves both the flags and the interrupt bits equal to the written control bits. No push appears while the queue is not ready. A pushed break word carries no character bits. An accepted external break sets the error bit. Some behaviour can only be shown by the bench's scenarios: the exhaustive sweeps of all control codes, pin codes and byte values, the dropping of external data in loopback, the edge-only behaviour of send-break, the stickiness of interrupt bits and the priority between simultaneous sources.

// File: rtl/modem_loop_unit.sv
module modem_loop_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_lbe,
  input  logic [3:0]        ctrl_mdm,
  input  logic              lcr_wr,
  input  logic              lcr_brk,
  input  logic              lcr_fifo,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ext_rx_valid,
  input  logic [DATA_W-1:0] ext_rx_data,
  input  logic              ext_break,
  input  logic [3:0]        modem_pin,
  input  logic [3:0]        ms_clr,
  input  logic              err_clr,
  input  logic              rxq_ready,
  output logic              rxq_push,
  output logic [DATA_W+2:0] rxq_word,
  output logic [3:0]        mdm_flags,
  output logic [3:0]        ms_irq,
  output logic              brk_err
);
  localparam int WORD_W = DATA_W + 3;
  localparam logic [WORD_W-1:0] BRK_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  logic       lbe_q, brk_q, fifo_q;
  logic [3:0] mdm_q, flg_q, ms_q;
  logic       brk_q_err;

  wire        lbe_nx = ctrl_wr ? ctrl_lbe : lbe_q;
  wire  [3:0] mdm_nx = ctrl_wr ? ctrl_mdm : mdm_q;
  wire  [3:0] flg_nx = lbe_nx ? mdm_nx : modem_pin;

  wire src_tx  = lbe_q & tx_wr;
  wire src_lb  = lbe_q & lcr_wr & lcr_brk & ~brk_q;
  wire src_xb  = ext_break & ~fifo_q;
  wire src_xr  = ext_rx_valid & ~lbe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lbe_q     <= 1'b0;
      mdm_q     <= '0;
      brk_q     <= 1'b0;
      fifo_q    <= 1'b0;
      flg_q     <= '0;
      ms_q      <= '0;
      brk_q_err <= 1'b0;
    end else begin
      lbe_q <= lbe_nx;
      mdm_q <= mdm_nx;
      if (lcr_wr) begin
        brk_q  <= lcr_brk;
        fifo_q <= lcr_fifo;
      end
      flg_q <= flg_nx;
      if (ctrl_wr && ctrl_lbe)
        ms_q <= ctrl_mdm;
      else if (!lbe_nx)
        ms_q <= (ms_q & ~ms_clr) | (modem_pin & ~flg_q);
      else
        ms_q <= ms_q & ~ms_clr;
      if (src_xb)
        brk_q_err <= 1'b1;
      else if (err_clr)
        brk_q_err <= 1'b0;
    end
  end

  always_comb begin
    rxq_word = '0;
    if (src_tx)
      rxq_word = {3'b000, tx_data};
    else if (src_lb || src_xb)
      rxq_word = BRK_WORD;
    else if (src_xr)
      rxq_word = {3'b000, ext_rx_data};
  end

  assign rxq_push  = rxq_ready & (src_tx | src_lb | src_xb | src_xr);
  assign mdm_flags = flg_q;
  assign ms_irq    = ms_q;
  assign brk_err   = brk_q_err;

  // R2 R3
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_lbe) |=> (mdm_flags == $past(ctrl_mdm)));

  // R4
  ms_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_lbe) |=> (ms_irq == $past(ctrl_mdm)));

  // R5
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lbe_q && !ctrl_wr) |=> (mdm_flags == $past(modem_pin)));

  // R10
  no_push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxq_ready |-> !rxq_push);

  // R7 R9
  brk_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_push && rxq_word[WORD_W-1]) |-> (rxq_word[WORD_W-2:0] == '0));

  // R9
  brk_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_break && !fifo_q) |=> brk_err);
endmodule

// File: tb/tb_modem_loop_unit.sv
module tb_modem_loop_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_lbe = 0, lcr_wr = 0, lcr_brk = 0, lcr_fifo = 0;
  logic tx_wr = 0, ext_rx_valid = 0, ext_break = 0, err_clr = 0, rxq_ready = 1;
  logic [3:0] ctrl_mdm = 0, modem_pin = 0, ms_clr = 0;
  logic [7:0] tx_data = 0, ext_rx_data = 0;
  logic rxq_push, brk_err;
  logic [10:0] rxq_word;
  logic [3:0] mdm_flags, ms_irq;
  int vecs = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  modem_loop_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ctrl_wr = 0; lcr_wr = 0; tx_wr = 0; ext_rx_valid = 0; ext_break = 0;
    err_clr = 0; ms_clr = 0; rxq_ready = 1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      vecs++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    step(); step();
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 flags", mdm_flags, 0);
    chk("R1 ms", ms_irq, 0);
    chk("R1 brk_err", brk_err, 0);
    chk("R1 push", rxq_push, 0);
    ext_rx_valid = 1; ext_rx_data = 8'h5a; #1;
    chk("R1 loopback off: ext rx passes", rxq_word, 11'h05a);
    idle();

    // R2 R3 R4 sweep of all control codes, pins set opposite
    for (int m = 0; m < 16; m++) begin
      modem_pin = ~m[3:0];
      ctrl_wr = 1; ctrl_lbe = 1; ctrl_mdm = m[3:0];
      step(); idle();
      chk("R3 map on enabling write", mdm_flags, m);
      chk("R4 ms rebuild", ms_irq, m);
      step();
      chk("R2 flags hold, pins ignored", mdm_flags, m);
    end

    // R6 byte sweep; R11 tx beats ext rx and ext break
    for (int d = 0; d < 256; d++) begin
      tx_wr = 1; tx_data = d[7:0];
      ext_rx_valid = d[0]; ext_rx_data = ~d[7:0]; ext_break = d[1];
      #1;
      chk("R6 push", rxq_push, 1);
      chk("R6 R11 word", rxq_word, d);
      step(); idle();
    end

    // R8 ext rx discarded in loopback
    ext_rx_valid = 1; ext_rx_data = 8'h33; #1;
    chk("R8 loopback drops ext rx", rxq_push, 0);
    idle();

    // R7 break edge
    lcr_wr = 1; lcr_brk = 1; lcr_fifo = 0; #1;
    chk("R7 rising break push", rxq_push, 1);
    chk("R7 break word", rxq_word, 11'h400);
    step();
    #1; chk("R7 held break no push", rxq_push, 0);
    step();
    lcr_brk = 0; #1;
    chk("R7 clearing break no push", rxq_push, 0);
    step(); idle();

    // R10 not ready
    rxq_ready = 0; tx_wr = 1; tx_data = 8'hA5; #1;
    chk("R10 no push when busy", rxq_push, 0);
    step(); idle();

    // leave loopback
    ctrl_wr = 1; ctrl_lbe = 0; ctrl_mdm = 4'hF; modem_pin = 0; ms_clr = 4'hF;
    step(); idle();
    chk("R5 flags from pins", mdm_flags, 0);

    // R5 pin sweep
    for (int p = 0; p < 16; p++) begin
      modem_pin = 0; ms_clr = 4'hF;
      step();
      ms_clr = 0;
      step();
      chk("R5 cleared", ms_irq, 0);
      modem_pin = p[3:0];
      step();
      chk("R5 flags follow pins", mdm_flags, p);
      chk("R5 ms set on rise", ms_irq, p);
      modem_pin = 0;
      step();
      chk("R5 ms sticky", ms_irq, p);
      ms_clr = 4'h5;
      step(); ms_clr = 0;
      chk("R5 partial clear", ms_irq, p & 4'hA);
    end

    // R8 ext rx passes
    for (int d = 0; d < 256; d += 17) begin
      ext_rx_valid = 1; ext_rx_data = d[7:0]; #1;
      chk("R8 ext rx push", rxq_push, 1);
      chk("R8 ext rx word", rxq_word, d);
      step(); idle();
    end

    // R6 tx not looped when loopback off
    tx_wr = 1; tx_data = 8'h11; #1;
    chk("R6 no tx loop when off", rxq_push, 0);
    idle();

    // R9 ext break, FIFO off; R11 beats ext rx
    ext_break = 1; ext_rx_valid = 1; ext_rx_data = 8'h77; #1;
    chk("R9 break push", rxq_push, 1);
    chk("R9 R11 break word", rxq_word, 11'h400);
    step(); idle();
    chk("R9 brk_err set", brk_err, 1);
    err_clr = 1; step(); idle();
    chk("R9 brk_err cleared", brk_err, 0);
    lcr_wr = 1; lcr_brk = 0; lcr_fifo = 1; step(); idle();
    ext_break = 1; #1;
    chk("R9 fifo on no push", rxq_push, 0);
    step(); idle();
    chk("R9 fifo on no error", brk_err, 0);

    finish_run();
  end
endmodule